// File: doc/BRIEF.md
# Free-Running Timer with Overflow Interrupt

This block is a 16-bit up-counter that acts as the shared time base for capture logic in a peripheral. It leaves reset already counting from zero. Each count is driven by a count tick. The tick is a power-of-two division of the bus clock, or it is a synchronized rising edge on an external input. Software reaches the block through two registers on a simple write strobe with a register select: a control register and a count register.

Software can freeze the counter, load a start value while it is frozen, and zero it at any time through a self-clearing clear bit. When the count wraps from its maximum back to zero, a sticky overflow flag is set. The flag raises an interrupt request while its enable bit is set.

The control register layout is: bit 0 halt, bit 1 clear (reads 0), bit 2 overflow flag, bit 3 overflow interrupt enable, bits 6:4 divide select, bit 7 external tick enable. Bits 15:8 read as 0 and should be written as 0. With `bus_sel` at 0 the control register is addressed, and with `bus_sel` at 1 the count register is addressed.

Top module: `frt_timer`

## Requirements
- R1: After reset the count is 0, every control field reads 0, and with the halt bit at 0 the count rises by one on each bus clock from the first edge after reset.
- R2: With the external enable at 0, divide select value s (bits 6:4) gives exactly one count step per 2^s bus clocks, for s from 0 to 7.
- R3: While halt (bit 0) is 1 the count holds its value. A write to the count register while halt is 0 has no effect on the count.
- R4: A write to the count register while halt is 1 loads the written value on the next clock edge. A written 0 clears the count. After halt returns to 0, counting resumes from the loaded value.
- R5: A count step at the maximum value 0xFFFF gives 0x0000 and sets the overflow flag (bit 2). Counting then continues upward.
- R6: `irq_o` is 1 exactly when the overflow flag and the interrupt enable (bit 3) are both 1. Clearing either of them drops the request one cycle after the write.
- R7: The overflow flag is sticky. A control write with bit 2 at 1 leaves it unchanged, and a control write with bit 2 at 0 clears it.
- R8: When an overflow occurs in the same cycle as a control write that clears the flag, the flag ends up set.
- R9: A control write with the clear bit (bit 1) at 1 forces the count to 0 on that write's clock edge, without waiting for a count tick. Bit 1 always reads back 0.
- R10: With the external enable (bit 7) at 1, the count advances once for each rising edge of `ext_tick_i`, after a two-flop synchronizer, and does not advance on the bus clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_sel | input | 1 | Register select: 0 control, 1 count |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| ext_tick_i | input | 1 | External count source, asynchronous |
| count_o | output | 16 | Live count value |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench uses the default parameters: a 16-bit count, a 3-bit divide select and two synchronizer stages. With these values every divide ratio up to 128 can be measured in a few hundred cycles. A wrap can be reached from a loaded start value of 0xFFFE within two ticks, so the cycle where an overflow meets a flag-clearing write can be placed exactly. The two-stage synchronizer lets external pulses of four bus clocks be counted without ambiguity.

// File: rtl/frt_pkg.sv
package frt_pkg;
    localparam int CNT_W      = 16;
    localparam int SEL_W      = 3;
    localparam int BIT_HALT   = 0;
    localparam int BIT_CLR    = 1;
    localparam int BIT_OVF    = 2;
    localparam int BIT_IE     = 3;
    localparam int BIT_SEL_LO = 4;
    localparam int BIT_EXT    = 7;

    typedef struct packed {
        logic             halt;
        logic             ie;
        logic [SEL_W-1:0] sel;
        logic             ext;
        logic             ovf;
    } ctl_t;
endpackage

// File: rtl/frt_tick_gen.sv
module frt_tick_gen #(
    parameter int SEL_W = 3,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             ext_en,
    input  logic             ext_in,
    output logic             tick
);
    localparam int PRE_W = (2 ** SEL_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [SYNC-1:0]  sync;
        logic             last;
    } tg_t;

    tg_t              s_d, s_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < int'(sel));
        end
        s_d      = s_q;
        s_d.pre  = s_q.pre + 1'b1;
        s_d.sync = {s_q.sync[SYNC-2:0], ext_in};
        s_d.last = s_q.sync[SYNC-1];
        if (ext_en) begin
            tick = s_q.sync[SYNC-1] & ~s_q.last;
        end else begin
            tick = ((s_q.pre & mask) == mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ct_t;

    ct_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        wrap = 1'b0;
        if (clr) begin
            s_d.cnt = '0;
        end else if (load) begin
            s_d.cnt = load_val;
        end else if (run && tick) begin
            s_d.cnt = s_q.cnt + 1'b1;
            wrap    = &s_q.cnt;
        end
        cnt = s_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/frt_ctl_regs.sv
module frt_ctl_regs
    import frt_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctl,
    input  logic [DW-1:0] wdata,
    input  logic          wrap,
    output ctl_t          ctl
);
    ctl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_ctl) begin
            s_d.halt = wdata[BIT_HALT];
            s_d.ie   = wdata[BIT_IE];
            s_d.sel  = wdata[BIT_SEL_LO +: SEL_W];
            s_d.ext  = wdata[BIT_EXT];
            if (!wdata[BIT_OVF]) s_d.ovf = 1'b0;
        end
        if (wrap) s_d.ovf = 1'b1;
        ctl = s_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/frt_timer.sv
module frt_timer
    import frt_pkg::*;
#(
    parameter int W      = CNT_W,
    parameter int SEL_WD = SEL_W,
    parameter int SYNC_N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic         bus_sel,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         ext_tick_i,
    output logic [W-1:0] count_o,
    output logic         irq_o
);
    ctl_t         ctl;
    logic         wr_ctl, wr_cnt, cnt_tick, cnt_wrap, sw_clr, ld;
    logic [W-1:0] cnt;
    logic [W-1:0] ctl_rd;

    always_comb begin
        wr_ctl = bus_wr & ~bus_sel;
        wr_cnt = bus_wr & bus_sel;
        sw_clr = wr_ctl & bus_wdata[BIT_CLR];
        ld     = wr_cnt & ctl.halt;
        ctl_rd = '0;
        ctl_rd[BIT_HALT]                = ctl.halt;
        ctl_rd[BIT_OVF]                 = ctl.ovf;
        ctl_rd[BIT_IE]                  = ctl.ie;
        ctl_rd[BIT_SEL_LO +: SEL_W]     = ctl.sel;
        ctl_rd[BIT_EXT]                 = ctl.ext;
        bus_rdata = bus_sel ? cnt : ctl_rd;
        count_o   = cnt;
        irq_o     = ctl.ovf & ctl.ie;
    end

    frt_ctl_regs #(.DW(W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_ctl(wr_ctl),
        .wdata (bus_wdata),
        .wrap  (cnt_wrap),
        .ctl   (ctl)
    );

    frt_tick_gen #(.SEL_W(SEL_WD), .SYNC(SYNC_N)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (ctl.sel),
        .ext_en(ctl.ext),
        .ext_in(ext_tick_i),
        .tick  (cnt_tick)
    );

    frt_counter #(.CNT_W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (~ctl.halt),
        .tick    (cnt_tick),
        .clr     (sw_clr),
        .load    (ld),
        .load_val(bus_wdata),
        .cnt     (cnt),
        .wrap    (cnt_wrap)
    );
endmodule

// File: rtl/frt_timer_chk.sv
module frt_timer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_ctl,
    input logic         wr_cnt,
    input logic [W-1:0] wdata,
    input logic         halt,
    input logic         tick,
    input logic [W-1:0] count,
    input logic         ovf,
    input logic         ie,
    input logic         irq
);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        halt && !wr_ctl && !wr_cnt |=> count == $past(count));

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        halt && wr_cnt |=> count == $past(wdata));

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !halt && tick && (&count) && !wr_ctl && !wr_cnt |=> count == '0 && ovf);

    p_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovf && ie);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !(wr_ctl && !wdata[2]) |=> ovf);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl && !wdata[2] && !wdata[1] && !halt && tick && (&count) |=> ovf);

    p_clr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl && wdata[1] |=> count == '0);
endmodule

bind frt_timer frt_timer_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_ctl(wr_ctl),
    .wr_cnt(wr_cnt),
    .wdata (bus_wdata),
    .halt  (ctl.halt),
    .tick  (cnt_tick),
    .count (cnt),
    .ovf   (ctl.ovf),
    .ie    (ctl.ie),
    .irq   (irq_o)
);

// File: tb/frt_timer_tb.sv
module frt_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_sel = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_tick_i = 1'b0;
    logic [15:0] count_o;
    logic        irq_o;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    frt_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_tick_i(ext_tick_i),
        .count_o   (count_o),
        .irq_o     (irq_o)
    );

    function automatic logic [15:0] cw(bit halt, bit clr, bit ovf, bit ie,
                                       int sel, bit ext);
        logic [15:0] v;
        v = '0;
        v[0] = halt; v[1] = clr; v[2] = ovf; v[3] = ie;
        v[6:4] = sel[2:0]; v[7] = ext;
        return v;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(bit sel, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_ctl(output logic [15:0] v);
        bus_sel = 1'b0;
        #1 v = bus_rdata;
    endtask

    task automatic preset(logic [15:0] val);
        wr(0, cw(1, 0, 0, 0, 0, 0));
        wr(1, val);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        @(negedge clk);
        check(count_o == 0, "R1 count in reset", count_o, 0);
        rd_ctl(v);
        check(v == 0, "R1 control in reset", v, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(count_o == 5, "R1 counting after reset", count_o, 5);
    endtask

    task automatic t_ratio();
        for (int s = 0; s < 8; s++) begin
            preset(16'h1000);
            wr(0, cw(0, 0, 0, 0, s, 0));
            repeat ((1 << s) * 3) @(negedge clk);
            check(count_o == 16'h1003, $sformatf("R2 divide select %0d", s),
                  count_o, 16'h1003);
        end
    endtask

    task automatic t_halt();
        logic [15:0] c;
        preset(16'h0234);
        repeat (10) @(negedge clk);
        check(count_o == 16'h0234, "R3 hold while halted", count_o, 16'h0234);
        wr(0, cw(0, 0, 0, 0, 0, 0));
        @(negedge clk);
        c = count_o;
        bus_wr = 1'b1; bus_sel = 1'b1; bus_wdata = 16'hABCD;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        check(count_o == c + 16'd1, "R3 count write ignored while running",
              count_o, c + 16'd1);
    endtask

    task automatic t_load();
        preset(16'h5A5A);
        check(count_o == 16'h5A5A, "R4 load while halted", count_o, 16'h5A5A);
        wr(1, 16'h0000);
        check(count_o == 0, "R4 load zero clears", count_o, 0);
        wr(1, 16'h0100);
        wr(0, cw(0, 0, 0, 0, 0, 0));
        repeat (4) @(negedge clk);
        check(count_o == 16'h0104, "R4 resume from loaded value", count_o, 16'h0104);
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        preset(16'hFFFE);
        wr(0, cw(0, 0, 0, 0, 0, 0));
        repeat (2) @(negedge clk);
        check(count_o == 0, "R5 wrap to zero", count_o, 0);
        rd_ctl(v);
        check(v[2] == 1'b1, "R5 overflow flag set", v[2], 1);
        check(irq_o == 1'b0, "R6 no request while disabled", irq_o, 0);
        @(negedge clk);
        check(count_o == 1, "R5 continues after wrap", count_o, 1);
    endtask

    task automatic t_irq();
        logic [15:0] v;
        wr(0, cw(0, 0, 1, 1, 0, 0));
        check(irq_o == 1'b1, "R6 request with flag and enable", irq_o, 1);
        wr(0, cw(0, 0, 1, 1, 0, 0));
        rd_ctl(v);
        check(v[2] == 1'b1, "R7 writing 1 keeps flag", v[2], 1);
        wr(0, cw(0, 0, 1, 0, 0, 0));
        check(irq_o == 1'b0, "R6 enable cleared drops request", irq_o, 0);
        wr(0, cw(0, 0, 0, 1, 0, 0));
        rd_ctl(v);
        check(v[2] == 1'b0, "R7 writing 0 clears flag", v[2], 0);
        check(irq_o == 1'b0, "R6 flag cleared drops request", irq_o, 0);
    endtask

    task automatic t_set_wins();
        logic [15:0] v;
        preset(16'hFFFE);
        wr(0, cw(0, 0, 0, 0, 0, 0));
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = 1'b0; bus_wdata = cw(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        rd_ctl(v);
        check(v[2] == 1'b1, "R8 overflow beats flag clear", v[2], 1);
        check(count_o == 0, "R8 count wrapped", count_o, 0);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        preset(16'h7000);
        wr(0, cw(0, 0, 0, 0, 7, 0));
        wr(0, cw(0, 1, 0, 0, 7, 0));
        check(count_o == 0, "R9 clear is immediate", count_o, 0);
        rd_ctl(v);
        check(v[1] == 1'b0, "R9 clear bit reads 0", v[1], 0);
    endtask

    task automatic t_ext();
        preset(16'h0000);
        wr(0, cw(0, 0, 0, 0, 0, 1));
        repeat (10) @(negedge clk);
        check(count_o == 0, "R10 no bus-clock counting", count_o, 0);
        for (int k = 0; k < 3; k++) begin
            ext_tick_i = 1'b1;
            repeat (4) @(negedge clk);
            ext_tick_i = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        check(count_o == 3, "R10 one step per external edge", count_o, 3);
    endtask

    initial begin
        t_reset();
        t_ratio();
        t_halt();
        t_load();
        t_wrap();
        t_irq();
        t_set_wins();
        t_clear();
        t_ext();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule